// File: doc/BRIEF.md
# Fully Associative Branch Target Cache

This block sits beside the fetch stage and remembers where recently executed taken branches went. Every cycle the current fetch address is compared against the branch address held in every entry at once. On a match the block flags a predicted-taken redirect and presents the remembered target as the speculative next fetch address. The match path is purely combinational inside the fetch cycle.

When a branch resolves in execute, the update port reports its address, whether it was taken, and its target. A taken branch that is not yet cached is written into the slot named by a round-robin pointer. A taken branch that is already cached has its target overwritten in place. A not-taken branch that is cached loses its entry, so a match always means taken. A synchronous flush input empties the whole cache. Instructions are word aligned, so the two lowest address bits play no part anywhere.

Top module: `btc_top`

## Requirements
- R1: After reset no entry is valid, so every lookup reports no hit.
- R2: When a valid entry holds the word address of `fetch_addr`, `pred_hit` is 1 and `pred_target` carries that entry's target in the same cycle; otherwise `pred_hit` is 0 and `pred_target` is all zeros.
- R3: Address bits [1:0] are ignored on `fetch_addr`, `upd_pc` and `upd_target`; bits [1:0] of `pred_target` are always 0.
- R4: A taken update whose address is not cached writes the slot named by a pointer that starts at slot 0 after reset and advances by one per such allocation, wrapping after the last slot; with all slots filled, the next allocation evicts the oldest allocated branch.
- R5: A taken update whose address is cached replaces that entry's target and leaves the pointer where it was.
- R6: A not-taken update whose address is cached invalidates that entry.
- R7: A not-taken update whose address is not cached changes nothing.
- R8: An update takes effect at the next clock edge; a lookup in the same cycle as an update to the same address sees the old contents.
- R9: `flush` invalidates every entry and returns the pointer to slot 0 at the next edge, and an update presented in the same cycle is discarded.
- R10: At most one entry ever matches a given address, so a single not-taken update removes a branch completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| fetch_addr | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | Lookup matched, predict taken |
| pred_target | output | ADDR_W | Predicted next fetch address on a hit, zero otherwise |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench fills all 64 slots and then allocates once more, so a pointer that skips, wraps wrongly or advances on an in-place refresh evicts the wrong branch and a later lookup hits or misses unexpectedly. It looks up an address in the very cycle it is updated, which catches a design that forwards the new write into the lookup. It re-trains an already cached branch and then retires it with one not-taken update, so a design that allocated a duplicate would keep hitting. It also presents low address bits that differ between install and lookup, and a flush together with an allocation, where a design letting the update win would show a stale hit.

// File: rtl/btc_pkg.sv
package btc_pkg;

    // Action selected for the update port in one cycle
    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ALLOC,
        ACT_RETARGET,
        ACT_DROP
    } upd_act_e;

    function automatic upd_act_e pick_action(input logic valid,
                                             input logic taken,
                                             input logic cached);
        if (!valid)              return ACT_NONE;
        else if (taken && cached) return ACT_RETARGET;
        else if (taken)           return ACT_ALLOC;
        else if (cached)          return ACT_DROP;
        else                      return ACT_NONE;
    endfunction

endpackage

// File: rtl/btc_match.sv
module btc_match #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 30,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_arr,
    input  logic [TAG_W-1:0]              key,
    output logic                          any_hit,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic [IDX_W-1:0]              hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tag_arr[g] == key);
    end

    assign any_hit = |hit_vec;

    // Lowest matching slot; only one can match while allocation is miss-only
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/btc_rr_ptr.sv
module btc_rr_ptr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)  ptr <= '0;
        else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Pointer steps by one slot per allocation and wraps after the last one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

    // Pointer holds when nothing is allocated (refresh leaves it alone)
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(ptr));

    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> ptr == '0);

endmodule

// File: rtl/btc_top.sv
module btc_top #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    import btc_pkg::*;

    localparam int TAG_W = ADDR_W - 2;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tgt_q;

    logic [TAG_W-1:0] fetch_word, upd_word, upd_tgt_word;
    assign fetch_word   = TAG_W'(fetch_addr >> 2);
    assign upd_word     = TAG_W'(upd_pc >> 2);
    assign upd_tgt_word = TAG_W'(upd_target >> 2);

    logic               lk_hit, up_hit;
    logic [ENTRIES-1:0] lk_vec, up_vec;
    logic [IDX_W-1:0]   lk_idx, up_idx, alloc_ptr;

    btc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lookup (
        .valid_vec (valid_q),
        .tag_arr   (tag_q),
        .key       (fetch_word),
        .any_hit   (lk_hit),
        .hit_vec   (lk_vec),
        .hit_idx   (lk_idx)
    );

    btc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_update (
        .valid_vec (valid_q),
        .tag_arr   (tag_q),
        .key       (upd_word),
        .any_hit   (up_hit),
        .hit_vec   (up_vec),
        .hit_idx   (up_idx)
    );

    upd_act_e act;
    assign act = flush ? ACT_NONE : pick_action(upd_valid, upd_taken, up_hit);

    btc_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk (clk),
        .rst (rst),
        .clr (flush),
        .adv (act == ACT_ALLOC),
        .ptr (alloc_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else begin
            unique case (act)
                ACT_ALLOC: begin
                    valid_q[alloc_ptr] <= 1'b1;
                    tag_q[alloc_ptr]   <= upd_word;
                    tgt_q[alloc_ptr]   <= upd_tgt_word;
                end
                ACT_RETARGET: tgt_q[up_idx]   <= upd_tgt_word;
                ACT_DROP:     valid_q[up_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    assign pred_hit    = lk_hit;
    assign pred_target = lk_hit ? {tgt_q[lk_idx], 2'b00} : '0;

    // No address ever lives in two slots
    assert_single_match_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(up_vec));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pred_hit && (valid_q == '0));

    // A not-taken resolution leaves no hit for that branch afterwards
    assert_drop_misses_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=>
            !(pred_hit && (fetch_word == $past(upd_word))));

    // A taken resolution is visible with its new target at the next cycle
    assert_taken_visible_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !flush) |=>
            (fetch_word != $past(upd_word)) ||
            (pred_hit && pred_target[ADDR_W-1:2] == $past(upd_tgt_word)));

    assert_target_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        pred_target[1:0] == 2'b00);

endmodule

// File: tb/btc_top_tb.sv
module btc_top_tb;

    localparam int AW = 32;
    localparam int NE = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          pred_hit;
    logic [AW-1:0] pred_target;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    always #4 clk = ~clk;

    btc_top #(.ADDR_W(AW), .ENTRIES(NE)) u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .fetch_addr(fetch_addr), .pred_hit(pred_hit), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    typedef struct {
        bit          chk;
        bit          hit;
        logic [AW-1:0] tgt;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference contents built from the requirements
    bit            m_val [NE];
    logic [AW-3:0] m_tag [NE];
    logic [AW-3:0] m_tgt [NE];
    int            m_ptr;

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < NE; i++)
            if (m_val[i] && m_tag[i] == a[AW-1:2]) return i;
        return -1;
    endfunction

    task automatic model_apply(input bit uv, input logic [AW-1:0] pc,
                               input bit tk, input logic [AW-1:0] tg, input bit fl);
        int h;
        if (fl) begin
            for (int i = 0; i < NE; i++) m_val[i] = 0;
            m_ptr = 0;
            return;
        end
        if (!uv) return;
        h = m_find(pc);
        if (tk && h >= 0) m_tgt[h] = tg[AW-1:2];
        else if (tk) begin
            m_val[m_ptr] = 1; m_tag[m_ptr] = pc[AW-1:2]; m_tgt[m_ptr] = tg[AW-1:2];
            m_ptr = (m_ptr + 1) % NE;
        end else if (h >= 0) m_val[h] = 0;
    endtask

    // Driver: one cycle of stimulus, one scoreboard item
    task automatic step(input logic [AW-1:0] fa, input bit uv, input logic [AW-1:0] pc,
                        input bit tk, input logic [AW-1:0] tg, input bit fl,
                        input bit chk, input string req);
        exp_t e;
        int h;
        @(posedge clk); #1;
        fetch_addr = fa; upd_valid = uv; upd_pc = pc;
        upd_taken = tk; upd_target = tg; flush = fl;
        h = m_find(fa);
        e.chk = chk; e.req = req;
        e.hit = (h >= 0);
        e.tgt = (h >= 0) ? {m_tgt[h], 2'b00} : '0;
        exp_q.push_back(e);
        model_apply(uv, pc, tk, tg, fl);
    endtask

    task automatic look(input logic [AW-1:0] fa, input string req);
        step(fa, 0, '0, 0, '0, 0, 1, req);
    endtask

    task automatic train(input logic [AW-1:0] pc, input bit tk,
                         input logic [AW-1:0] tg, input string req);
        step(32'h0, 1, pc, tk, tg, 0, 0, req);
    endtask

    // Monitor: compare in the middle of each driven cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.chk) begin
                checks++;
                if (pred_hit !== e.hit || pred_target !== e.tgt) begin
                    errors++;
                    $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                             e.req, pred_hit, pred_target, e.hit, e.tgt);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) m_val[i] = 0;
        m_ptr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset
        look(32'h0000_0000, "R1");
        look(32'h0000_1000, "R1");

        // R2 / R3: install with stray low bits, look up with other low bits
        train(32'h0000_2002, 1, 32'h0000_8003, "R3");
        look(32'h0000_2000, "R2");
        look(32'h0000_2003, "R3");
        look(32'h0000_2004, "R2");

        // R8: lookup of the same branch in its install cycle sees the old state
        step(32'h0000_3000, 1, 32'h0000_3000, 1, 32'h0000_9000, 0, 1, "R8");
        look(32'h0000_3000, "R8");

        // R5 / R10: re-train cached branch, then one not-taken removes it
        train(32'h0000_2000, 1, 32'h0000_A000, "R5");
        look(32'h0000_2000, "R5");
        step(32'h0000_2000, 1, 32'h0000_2000, 0, '0, 0, 1, "R8");
        look(32'h0000_2000, "R10");

        // R7: not-taken miss touches nothing
        train(32'h0000_4000, 0, 32'h0000_5000, "R7");
        look(32'h0000_4000, "R7");
        look(32'h0000_3000, "R7");

        // R9: flush with a same-cycle allocation
        step(32'h0, 1, 32'h0000_6000, 1, 32'h0000_7000, 1, 0, "R9");
        look(32'h0000_3000, "R9");
        look(32'h0000_6000, "R9");

        // R4: fill every slot from slot 0, refresh one mid-way, then overflow
        for (int i = 0; i < NE; i++) begin
            train(32'h0001_0000 + 4 * i, 1, 32'h0002_0000 + 4 * i, "R4");
            if (i == 10) train(32'h0001_0000, 1, 32'h0003_0000, "R5");
        end
        look(32'h0001_0000, "R5");
        look(32'h0001_0000 + 4 * (NE - 1), "R4");
        train(32'h0004_0000, 1, 32'h0005_0000, "R4");
        look(32'h0001_0000, "R4");
        look(32'h0001_0004, "R4");
        look(32'h0004_0000, "R4");
        train(32'h0004_0004, 1, 32'h0005_0004, "R4");
        look(32'h0001_0004, "R4");
        look(32'h0001_0008, "R4");

        step(32'h0, 0, '0, 0, '0, 0, 0, "idle");
        step(32'h0, 0, '0, 0, '0, 0, 0, "idle");
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule